// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block conditions a group of external interrupt request lines (sixteen by default) and one non-maskable request input before they reach a parent interrupt controller. Every raw input is synchronised to the block clock. Each line then has a 2-bit detection mode: active-low level, falling edge, rising edge or both edges. The non-maskable input detects either a falling or a rising edge. A detection sets a status flag. Each flag drives an active-high level request toward the parent for as long as it stays set.

Software reaches the block through a generic 32-bit register port. The port has a write strobe, a byte address, write data and a combinational read path. Edge-latched flags stay set until software writes a one to the matching bit of a clear register. A flag in low-level mode follows the synchronised input instead, and clear writes do not affect it. Changing a line's mode does not set its flag. After reconfiguring a line, software is expected to clear any stale edge flag.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset every line flag and the non-maskable flag are 0, all request outputs are low, the line mode register (0x18) reads 0 and the non-maskable edge select (0x08) reads 0.
- R2: The mode of line n is held in bits [2n+1:2n] of the register at 0x18 and reads back as written; the encoding is 0 = low level, 1 = falling edge, 2 = rising edge, 3 = both edges.
- R3: In mode 1 a falling input sets the line flag and a rising input does not.
- R4: In mode 2 a rising input sets the line flag and a falling input does not.
- R5: In mode 3 both a falling and a rising input set the line flag.
- R6: In mode 0 the flag is 1 while the synchronised input is low and returns to 0 by itself when the input goes high.
- R7: In mode 0, writing ones to the line clear register (0x14) leaves the flag unchanged.
- R8: In an edge mode, writing the clear register (0x14) clears flag n exactly when bit n of the written data is 1; other flags keep their value.
- R9: If a qualifying edge and a clear write for the same bit take effect in the same cycle, the flag ends up set.
- R10: The non-maskable input sets its flag on a falling edge when bit 0 of 0x08 is 0 and on a rising edge when it is 1; 0x08 reads back the select bit.
- R11: Writing 1 to bit 0 of 0x04 clears the non-maskable flag; bit 0 of 0x00 reads that flag.
- R12: Each request output equals its flag, and the line status register at 0x10 reads the line flags with line n at bit n.
- R13: An input change is first visible on a request output after the third rising clock edge following the change, never after the second.
- R14: Writing a line's mode does not set its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NUM_LINES | Raw external request lines, asynchronous |
| nmi_in | input | 1 | Raw non-maskable request, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr, combinational |
| irq_out | output | NUM_LINES | Active-high level requests to the parent, one per line |
| nmi_out | output | 1 | Active-high level non-maskable request to the parent |

## Verification
The assertions assume that the raw inputs are clean digital levels. They also assume that a clear write lasts exactly one clock cycle per strobe, so every write is a single-cycle event whose effect lands on the next edge. The bench changes inputs and register controls only on falling clock edges. It holds each input level for several cycles, so each change yields exactly one synchronised edge. It places the colliding clear write on the exact edge at which the edge detector fires.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int NUM_LINES = 16,
  parameter int AW        = 8,
  parameter int DW        = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 nmi_in,
  input  logic                 reg_we,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic [NUM_LINES-1:0] irq_out,
  output logic                 nmi_out
);
  localparam int MW = 2 * NUM_LINES;
  localparam logic [AW-1:0] A_NSTAT = AW'(8'h00);
  localparam logic [AW-1:0] A_NCLR  = AW'(8'h04);
  localparam logic [AW-1:0] A_NSEL  = AW'(8'h08);
  localparam logic [AW-1:0] A_LSTAT = AW'(8'h10);
  localparam logic [AW-1:0] A_LCLR  = AW'(8'h14);
  localparam logic [AW-1:0] A_LMODE = AW'(8'h18);

  logic [NUM_LINES-1:0] ln_s1, ln_s2, ln_s3, flag, hit, clr;
  logic [MW-1:0]        mode;
  logic                 nmi_s1, nmi_s2, nmi_s3, nmi_flag, nmi_sel;

  wire wr_lclr  = reg_we && (reg_addr == A_LCLR);
  wire wr_mode  = reg_we && (reg_addr == A_LMODE);
  wire wr_nclr  = reg_we && (reg_addr == A_NCLR) && reg_wdata[0];
  wire wr_nsel  = reg_we && (reg_addr == A_NSEL);
  wire nmi_hit  = nmi_sel ? (!nmi_s3 && nmi_s2) : (nmi_s3 && !nmi_s2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ln_s1   <= '1;
      ln_s2   <= '1;
      ln_s3   <= '1;
      nmi_s1  <= 1'b1;
      nmi_s2  <= 1'b1;
      nmi_s3  <= 1'b1;
    end else begin
      ln_s1   <= line_in;
      ln_s2   <= ln_s1;
      ln_s3   <= ln_s2;
      nmi_s1  <= nmi_in;
      nmi_s2  <= nmi_s1;
      nmi_s3  <= nmi_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= '0;
      nmi_sel <= 1'b0;
    end else begin
      if (wr_mode) mode <= reg_wdata[MW-1:0];
      if (wr_nsel) nmi_sel <= reg_wdata[0];
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LINES; gi++) begin : g_line
      wire [1:0] m    = mode[2*gi +: 2];
      wire       fell = ln_s3[gi] && !ln_s2[gi];
      wire       rose = !ln_s3[gi] && ln_s2[gi];
      assign hit[gi] = (m == 2'd1 && fell) || (m == 2'd2 && rose) ||
                       (m == 2'd3 && (fell || rose));
      assign clr[gi] = wr_lclr && reg_wdata[gi];

      p_clear_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m != 2'd0 && clr[gi] && !hit[gi]) |=> !flag[gi]);
      p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m != 2'd0 && hit[gi]) |=> flag[gi]);
      p_level_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m == 2'd0) |=> (flag[gi] == !$past(ln_s2[gi])));
      p_edge_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (m != 2'd0 && !hit[gi] && !clr[gi]) |=> $stable(flag[gi]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= '0;
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (mode[2*i +: 2] == 2'd0) flag[i] <= !ln_s2[i];
        else                        flag[i] <= hit[i] || (flag[i] && !clr[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_flag <= 1'b0;
    else        nmi_flag <= nmi_hit || (nmi_flag && !wr_nclr);
  end

  p_nmi_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_flag) |-> $past(nmi_hit));
  p_nmi_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_nclr && !nmi_hit) |=> !nmi_flag);

  assign irq_out = flag;
  assign nmi_out = nmi_flag;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_NSTAT: reg_rdata[0] = nmi_flag;
      A_NSEL:  reg_rdata[0] = nmi_sel;
      A_LSTAT: reg_rdata[NUM_LINES-1:0] = flag;
      A_LMODE: reg_rdata[MW-1:0] = mode;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/test_ext_irq_sense.sv
module test_ext_irq_sense;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 0, rst_n = 0, nmi_in = 1, reg_we = 0;
  logic [N-1:0] line_in = '1;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [N-1:0] irq_out;
  logic        nmi_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  ext_irq_sense i_ext_irq_sense (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .nmi_in(nmi_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out), .nmi_out(nmi_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_line(int i, logic v);
    @(negedge clk);
    line_in[i] = v;
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_out", 32'(irq_out), 0);
    chk("R1 nmi_out", 32'(nmi_out), 0);
    rd(8'h18, d); chk("R1 mode reg", d, 0);
    rd(8'h08, d); chk("R1 nmi select", d, 0);
    rd(8'h10, d); chk("R1 line status", d, 0);
    rd(8'h00, d); chk("R1 nmi status", d, 0);
  endtask

  task automatic t_mode();
    logic [31:0] d;
    wr(8'h18, 32'h0000_0039);
    rd(8'h18, d); chk("R2 mode readback", d, 32'h0000_0039);
    settle();
    chk("R14 mode write sets no flag", 32'(irq_out), 0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    line_in[1] = 0;
    settle();
    chk("R4 falling ignored in rising mode", 32'(irq_out[1]), 0);
    @(negedge clk);
    line_in[1] = 1;
    repeat (2) @(posedge clk);
    #1 chk("R13 not after second edge", 32'(irq_out[1]), 0);
    @(posedge clk);
    #1 chk("R13 visible after third edge", 32'(irq_out[1]), 1);
    chk("R4 rising sets flag", 32'(irq_out[1]), 1);
  endtask

  task automatic t_fall_clear();
    logic [31:0] d;
    set_line(0, 0);
    chk("R3 falling sets flag", 32'(irq_out[0]), 1);
    rd(8'h10, d); chk("R12 status matches", d, 32'h3);
    wr(8'h14, 32'h1);
    chk("R8 bit0 cleared", 32'(irq_out[0]), 0);
    chk("R8 bit1 untouched", 32'(irq_out[1]), 1);
    set_line(0, 1);
    chk("R3 rising ignored in falling mode", 32'(irq_out[0]), 0);
    wr(8'h14, 32'h2);
    chk("R8 bit1 cleared", 32'(irq_out), 0);
  endtask

  task automatic t_both();
    set_line(2, 0);
    chk("R5 falling in both mode", 32'(irq_out[2]), 1);
    wr(8'h14, 32'h4);
    chk("R8 clear both-mode flag", 32'(irq_out[2]), 0);
    set_line(2, 1);
    chk("R5 rising in both mode", 32'(irq_out[2]), 1);
    wr(8'h14, 32'h4);
  endtask

  task automatic t_level();
    logic [31:0] d;
    set_line(4, 0);
    chk("R6 level low sets flag", 32'(irq_out[4]), 1);
    wr(8'h14, 32'h0000_0010);
    chk("R7 clear ignored in level mode", 32'(irq_out[4]), 1);
    rd(8'h10, d); chk("R12 status level bit", d, 32'h10);
    set_line(4, 1);
    chk("R6 level flag self clears", 32'(irq_out[4]), 0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    line_in[0] = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    reg_we = 1; reg_addr = 8'h14; reg_wdata = 32'h1;
    @(posedge clk);
    #1 chk("R9 edge wins over clear", 32'(irq_out[0]), 1);
    @(negedge clk);
    reg_we = 0; reg_wdata = '0;
    wr(8'h14, 32'h1);
    set_line(0, 1);
  endtask

  task automatic t_nmi();
    logic [31:0] d;
    @(negedge clk); nmi_in = 0; settle();
    chk("R10 nmi falling sets", 32'(nmi_out), 1);
    rd(8'h00, d); chk("R11 nmi status read", d, 1);
    wr(8'h04, 32'h1);
    chk("R11 nmi cleared", 32'(nmi_out), 0);
    wr(8'h08, 32'h1);
    rd(8'h08, d); chk("R10 nmi select readback", d, 1);
    @(negedge clk); nmi_in = 1; settle();
    chk("R10 nmi rising sets", 32'(nmi_out), 1);
    wr(8'h04, 32'h1);
    @(negedge clk); nmi_in = 0; settle();
    chk("R10 nmi falling ignored in rising", 32'(nmi_out), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mode();
    t_latency();
    t_fall_clear();
    t_both();
    t_level();
    t_collide();
    t_nmi();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule